// File: doc/BRIEF.md
# Cache Set Status Readout Unit

This unit executes a "read set status" operation for a data cache. An issuing slot presents a base register value and a signed, word-aligned immediate. The unit adds them and takes the set number from bits 10 down to 6 of the sum. It then looks up that set's replacement code and per-way dirty flags, and packs them into a zero-extended 32-bit result. Three cycles after issue it produces a destination register write, or suppresses that write.

There are two copies of the status store, one for each issue port. A read always uses the copy that belongs to the port that issued it. Each copy also has a simple load path, so a test environment can place any replacement code and dirty pattern into any set. Both copies may be loaded in the same cycle to keep them alike. A guard input decides whether the write happens. An immediate that is out of range or misaligned raises an illegal-operand flag instead of a write. Each accepted operation holds the issue pipeline stalled for two cycles.

Top module: `cache_status_reader`

## Requirements
- R1: The set index is bits [10:6] of `issue_base` plus `issue_offset` sign-extended to 32 bits.
- R2: `issue_offset` is legal only when it lies between -256 and 252 and its two low bits are 0. An illegal offset makes `illegal` pulse high in the result cycle, with `wr_en` low. This happens whatever the guard is.
- R3: In a written result, bits [9:0] hold the 10-bit replacement code, bits [17:10] hold the 8 dirty flags (bit 10+w belongs to way w), and bits [31:18] are 0.
- R4: An operation issued with `issue_port` = p reads status copy p only.
- R5: When `upd_en[p]` is high at a clock edge, copy p stores `upd_lru` and `upd_dirty` for set `upd_set`. With both bits set, both copies are written in the same edge.
- R6: With `guard_present` high, only bit 0 of `guard_value` counts. When it is 0, neither `wr_en` nor `illegal` rises for a legal operation.
- R7: With `guard_present` low, a legal operation always writes.
- R8: An operation is sampled at the clock edge that ends its issue cycle. `wr_en`, `wr_idx` (equal to the issued `dest_idx`) and `wr_data` are valid in the third cycle after the issue cycle. `wr_en` is high for exactly that one cycle.
- R9: `stall` is high for exactly the two cycles that follow an accepted issue. `issue_valid` is ignored while `stall` is high.
- R10: During and right after reset, `stall`, `wr_en`, `illegal`, `wr_idx` and `wr_data` are 0, and every set of both copies reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| issue_port | input | 1 | Issue port number, which selects the status copy |
| issue_base | input | 32 | Base register value |
| issue_offset | input | 10 | Signed immediate offset |
| guard_present | input | 1 | The operation carries a guard |
| guard_value | input | 32 | Guard register value; only bit 0 is used |
| dest_idx | input | 7 | Destination register index |
| upd_en | input | 2 | Per-copy status load enable |
| upd_set | input | 5 | Set to load |
| upd_lru | input | 10 | Replacement code to load |
| upd_dirty | input | 8 | Dirty flags to load |
| stall | output | 1 | Issue pipeline stall |
| wr_en | output | 1 | Destination write pulse |
| wr_idx | output | 7 | Destination register index |
| wr_data | output | 32 | Packed status result |
| illegal | output | 1 | Illegal-offset flag, in the result cycle |

## Verification
The latency, index and guard properties look three edges back. They therefore assume that `issue_valid` stays low while reset is held and that the request fields are known whenever `issue_valid` is high. The stimulus never loads a set in the same cycle as a read of that set, so each expected value matches the store contents before the read. Every request is driven on the falling edge for a single cycle. The one exception is a deliberate repeat during the stall window, which checks that the repeat is dropped.

// File: rtl/csr_pkg.sv
package csr_pkg;
  // Fixed pipeline depth: decode, array read, result register
  localparam int CSR_LATENCY = 3;

  typedef enum logic [1:0] {
    CSR_OP_NONE    = 2'd0,
    CSR_OP_WRITE   = 2'd1,
    CSR_OP_SQUASH  = 2'd2,
    CSR_OP_ILLEGAL = 2'd3
  } csr_op_e;
endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode #(
  parameter int SUM_W   = 11,
  parameter int OFF_W   = 10,
  parameter int SET_W   = 5,
  parameter int SET_LSB = 6,
  parameter int OFF_MIN = -256,
  parameter int OFF_MAX = 252,
  parameter int ALIGN_B = 2
) (
  input  logic [SUM_W-1:0] base_lo,
  input  logic [OFF_W-1:0] offset,
  output logic [SET_W-1:0] set_idx,
  output logic             legal
);
  logic [SUM_W-1:0] off_ext;
  logic [SUM_W-1:0] sum;
  logic             unused_sum_lo;
  logic             in_range;
  logic             aligned;

  assign off_ext       = {{(SUM_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign sum           = base_lo + off_ext;
  assign set_idx       = sum[SET_LSB +: SET_W];
  assign unused_sum_lo = ^sum[SET_LSB-1:0];

  always_comb begin
    in_range = ($signed(offset) >= OFF_MIN) && ($signed(offset) <= OFF_MAX);
    aligned  = (offset[ALIGN_B-1:0] == '0);
    legal    = in_range && aligned;
  end
endmodule

// File: rtl/csr_status_bank.sv
module csr_status_bank #(
  parameter int SETS  = 32,
  parameter int SET_W = 5,
  parameter int LRU_W = 10,
  parameter int WAYS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SET_W-1:0] ld_set,
  input  logic [LRU_W-1:0] ld_lru,
  input  logic [WAYS-1:0]  ld_dirty,
  input  logic             rd_en,
  input  logic [SET_W-1:0] rd_set,
  output logic [LRU_W-1:0] rd_lru,
  output logic [WAYS-1:0]  rd_dirty
);
  logic [LRU_W-1:0] lru_q   [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [LRU_W-1:0] rd_lru_d;
  logic [WAYS-1:0]  rd_dirty_d;

  for (genvar gi = 0; gi < SETS; gi++) begin : g_set
    logic hit;
    assign hit = ld_en && (ld_set == SET_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lru_q[gi]   <= '0;
        dirty_q[gi] <= '0;
      end else if (hit) begin
        lru_q[gi]   <= ld_lru;
        dirty_q[gi] <= ld_dirty;
      end
    end
  end

  always_comb begin
    rd_lru_d   = lru_q[rd_set];
    rd_dirty_d = dirty_q[rd_set];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_lru   <= '0;
      rd_dirty <= '0;
    end else if (rd_en) begin
      rd_lru   <= rd_lru_d;
      rd_dirty <= rd_dirty_d;
    end
  end
endmodule

// File: rtl/csr_result_pack.sv
module csr_result_pack #(
  parameter int XLEN  = 32,
  parameter int LRU_W = 10,
  parameter int WAYS  = 8
) (
  input  logic [LRU_W-1:0] lru,
  input  logic [WAYS-1:0]  dirty,
  output logic [XLEN-1:0]  word
);
  localparam int PAD_W = XLEN - LRU_W - WAYS;

  assign word = {{PAD_W{1'b0}}, dirty, lru};
endmodule

// File: rtl/cache_status_reader.sv
module cache_status_reader
  import csr_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SETS    = 32,
  parameter int NPORTS  = 2,
  parameter int LRU_W   = 10,
  parameter int WAYS    = 8,
  parameter int OFF_W   = 10,
  parameter int IDX_W   = 7,
  parameter int SET_LSB = 6,
  parameter int OFF_MIN = -256,
  parameter int OFF_MAX = 252,
  parameter int SET_W   = $clog2(SETS),
  parameter int PORT_W  = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [PORT_W-1:0] issue_port,
  input  logic [XLEN-1:0]   issue_base,
  input  logic [OFF_W-1:0]  issue_offset,
  input  logic              guard_present,
  input  logic [XLEN-1:0]   guard_value,
  input  logic [IDX_W-1:0]  dest_idx,
  input  logic [NPORTS-1:0] upd_en,
  input  logic [SET_W-1:0]  upd_set,
  input  logic [LRU_W-1:0]  upd_lru,
  input  logic [WAYS-1:0]   upd_dirty,
  output logic              stall,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              illegal
);
  localparam int SUM_W     = SET_LSB + SET_W;
  localparam int STALL_CYC = CSR_LATENCY - 1;
  localparam int CNT_W     = $clog2(STALL_CYC + 1);

  // Issue acceptance and stall counter
  logic             accept;
  logic [CNT_W-1:0] stall_cnt_q, stall_cnt_d;
  logic             unused_hi;

  assign unused_hi = ^{issue_base[XLEN-1:SUM_W], guard_value[XLEN-1:1]};
  assign accept    = issue_valid && (stall_cnt_q == '0);

  always_comb begin
    stall_cnt_d = stall_cnt_q;
    if (accept)                 stall_cnt_d = CNT_W'(STALL_CYC);
    else if (stall_cnt_q != '0) stall_cnt_d = stall_cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_cnt_q <= '0;
    else        stall_cnt_q <= stall_cnt_d;
  end

  assign stall = (stall_cnt_q != '0);

  // Address decode
  logic [SET_W-1:0] dec_set;
  logic             dec_legal;

  csr_addr_decode #(
    .SUM_W  (SUM_W),
    .OFF_W  (OFF_W),
    .SET_W  (SET_W),
    .SET_LSB(SET_LSB),
    .OFF_MIN(OFF_MIN),
    .OFF_MAX(OFF_MAX),
    .ALIGN_B(2)
  ) u_dec (
    .base_lo(issue_base[SUM_W-1:0]),
    .offset (issue_offset),
    .set_idx(dec_set),
    .legal  (dec_legal)
  );

  // Stage 1: decoded request
  csr_op_e           s1_op_q,   s1_op_d;
  logic [PORT_W-1:0] s1_port_q;
  logic [SET_W-1:0]  s1_set_q;
  logic [IDX_W-1:0]  s1_idx_q;
  logic              guard_ok;

  assign guard_ok = !guard_present || guard_value[0];

  always_comb begin
    s1_op_d = CSR_OP_NONE;
    if (accept) begin
      if (!dec_legal)    s1_op_d = CSR_OP_ILLEGAL;
      else if (guard_ok) s1_op_d = CSR_OP_WRITE;
      else               s1_op_d = CSR_OP_SQUASH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q   <= CSR_OP_NONE;
      s1_port_q <= '0;
      s1_set_q  <= '0;
      s1_idx_q  <= '0;
    end else begin
      s1_op_q <= s1_op_d;
      if (accept) begin
        s1_port_q <= issue_port;
        s1_set_q  <= dec_set;
        s1_idx_q  <= dest_idx;
      end
    end
  end

  // Status copies, one per issue port
  logic [LRU_W-1:0] bank_lru   [NPORTS];
  logic [WAYS-1:0]  bank_dirty [NPORTS];

  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_bank
    logic rd_here;
    assign rd_here = (s1_op_q == CSR_OP_WRITE) && (s1_port_q == PORT_W'(gp));

    csr_status_bank #(
      .SETS (SETS),
      .SET_W(SET_W),
      .LRU_W(LRU_W),
      .WAYS (WAYS)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (upd_en[gp]),
      .ld_set  (upd_set),
      .ld_lru  (upd_lru),
      .ld_dirty(upd_dirty),
      .rd_en   (rd_here),
      .rd_set  (s1_set_q),
      .rd_lru  (bank_lru[gp]),
      .rd_dirty(bank_dirty[gp])
    );
  end

  // Stage 2: request travels beside the array read
  csr_op_e           s2_op_q;
  logic [PORT_W-1:0] s2_port_q;
  logic [IDX_W-1:0]  s2_idx_q;
  logic              s1_live;

  assign s1_live = (s1_op_q != CSR_OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op_q   <= CSR_OP_NONE;
      s2_port_q <= '0;
      s2_idx_q  <= '0;
    end else begin
      s2_op_q <= s1_op_q;
      if (s1_live) begin
        s2_port_q <= s1_port_q;
        s2_idx_q  <= s1_idx_q;
      end
    end
  end

  // Result packing and output register
  logic [XLEN-1:0] packed_word;
  logic            wr_en_d, illegal_d;

  csr_result_pack #(
    .XLEN (XLEN),
    .LRU_W(LRU_W),
    .WAYS (WAYS)
  ) u_pack (
    .lru  (bank_lru[s2_port_q]),
    .dirty(bank_dirty[s2_port_q]),
    .word (packed_word)
  );

  always_comb begin
    wr_en_d   = (s2_op_q == CSR_OP_WRITE);
    illegal_d = (s2_op_q == CSR_OP_ILLEGAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      illegal <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= wr_en_d;
      illegal <= illegal_d;
      if (wr_en_d) begin
        wr_idx  <= s2_idx_q;
        wr_data <= packed_word;
      end
    end
  end
endmodule

// File: rtl/csr_checker.sv
module csr_checker #(
  parameter int XLEN  = 32,
  parameter int LRU_W = 10,
  parameter int WAYS  = 8,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_valid,
  input logic             guard_present,
  input logic             guard_lsb,
  input logic [IDX_W-1:0] dest_idx,
  input logic             stall,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [XLEN-1:0]  wr_data,
  input logic             illegal
);
  AST_STALL_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !stall) |=> stall); // R9
  AST_STALL_TWO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |=> !stall); // R9
  AST_WR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(issue_valid && !stall, 3)); // R8
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R8
  AST_WR_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx == $past(dest_idx, 3))); // R8
  AST_GUARD_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!guard_present || guard_lsb, 3)); // R6
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[XLEN-1:LRU_W+WAYS] == '0)); // R3
endmodule

bind cache_status_reader csr_checker #(
  .XLEN (XLEN),
  .LRU_W(LRU_W),
  .WAYS (WAYS),
  .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .issue_valid  (issue_valid),
  .guard_present(guard_present),
  .guard_lsb    (guard_value[0]),
  .dest_idx     (dest_idx),
  .stall        (stall),
  .wr_en        (wr_en),
  .wr_idx       (wr_idx),
  .wr_data      (wr_data),
  .illegal      (illegal)
);

// File: tb/tb_cache_status_reader.sv
module tb_cache_status_reader;
  logic        clk;
  logic        rst_n;
  logic        issue_valid;
  logic        issue_port;
  logic [31:0] issue_base;
  logic [9:0]  issue_offset;
  logic        guard_present;
  logic [31:0] guard_value;
  logic [6:0]  dest_idx;
  logic [1:0]  upd_en;
  logic [4:0]  upd_set;
  logic [9:0]  upd_lru;
  logic [7:0]  upd_dirty;
  logic        stall;
  logic        wr_en;
  logic [6:0]  wr_idx;
  logic [31:0] wr_data;
  logic        illegal;

  cache_status_reader dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_port(issue_port),
    .issue_base(issue_base), .issue_offset(issue_offset),
    .guard_present(guard_present), .guard_value(guard_value), .dest_idx(dest_idx),
    .upd_en(upd_en), .upd_set(upd_set), .upd_lru(upd_lru), .upd_dirty(upd_dirty),
    .stall(stall), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [9:0]  m_lru   [2][32];
  logic [7:0]  m_dirty [2][32];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic load(input logic [1:0] mask, input int s, input logic [9:0] l, input logic [7:0] d);
    upd_en = mask; upd_set = 5'(s); upd_lru = l; upd_dirty = d;
    @(negedge clk);
    upd_en = 2'b00;
    for (int p = 0; p < 2; p++) if (mask[p]) begin m_lru[p][s] = l; m_dirty[p][s] = d; end
  endtask

  // Drives one operation and checks every cycle up to one past the result
  task automatic run_op(input int port, input logic [31:0] base, input int off,
                        input bit gp, input logic [31:0] g, input logic [6:0] idx,
                        input bit repeat_in_stall, input string tag);
    logic [31:0] sum;
    int          s;
    bit          legal, exp_wr, exp_ill;
    logic [31:0] exp_data;
    sum      = base + 32'(off);
    s        = int'(sum[10:6]);
    legal    = (off >= -256) && (off <= 252) && (off % 4 == 0);
    exp_ill  = !legal;
    exp_wr   = legal && (!gp || g[0]);
    exp_data = {14'd0, m_dirty[port][s], m_lru[port][s]};
    issue_valid = 1'b1; issue_port = port[0]; issue_base = base;
    issue_offset = 10'(off); guard_present = gp; guard_value = g; dest_idx = idx;
    @(negedge clk);
    if (repeat_in_stall) begin
      dest_idx = idx ^ 7'h55; guard_present = 1'b0; issue_offset = 10'd0;
    end else issue_valid = 1'b0;
    chk(stall === 1'b1, {"R9 stall cycle1 ", tag}, 32'(stall), 1);
    chk(wr_en === 1'b0 && illegal === 1'b0, {"R8 early output ", tag}, 32'({wr_en, illegal}), 0);
    @(negedge clk);
    issue_valid = repeat_in_stall;
    chk(stall === 1'b1, {"R9 stall cycle2 ", tag}, 32'(stall), 1);
    @(negedge clk);
    issue_valid = 1'b0;
    chk(stall === 1'b0, {"R9 stall release ", tag}, 32'(stall), 0);
    chk(wr_en === exp_wr, {"R6 R7 R8 write enable ", tag}, 32'(wr_en), 32'(exp_wr));
    chk(illegal === exp_ill, {"R2 illegal flag ", tag}, 32'(illegal), 32'(exp_ill));
    if (exp_wr) begin
      chk(wr_data === exp_data, {"R1 R3 R4 R5 data ", tag}, wr_data, exp_data);
      chk(wr_idx === idx, {"R8 index ", tag}, 32'(wr_idx), 32'(idx));
    end
    @(negedge clk);
    chk(wr_en === 1'b0 && illegal === 1'b0, {"R8 single pulse ", tag}, 32'({wr_en, illegal}), 0);
    if (repeat_in_stall) begin
      @(negedge clk);
      chk(wr_en === 1'b0 && stall === 1'b0, {"R9 dropped repeat ", tag}, 32'({wr_en, stall}), 0);
    end
  endtask

  function automatic logic [31:0] base_for(input int s, input int off);
    logic [31:0] r;
    r = nxt();
    return {r[31:11], 5'(s), r[5:0] & 6'h3C} - 32'(off);
  endfunction

  initial begin
    int offs[6] = '{-256, -4, 0, 252, 64, -128};
    rst_n = 1'b0; issue_valid = 1'b0; issue_port = 1'b0; issue_base = '0;
    issue_offset = '0; guard_present = 1'b0; guard_value = '0; dest_idx = '0;
    upd_en = '0; upd_set = '0; upd_lru = '0; upd_dirty = '0;
    for (int p = 0; p < 2; p++) for (int s = 0; s < 32; s++) begin
      m_lru[p][s] = '0; m_dirty[p][s] = '0;
    end
    repeat (3) @(negedge clk);
    chk({stall, wr_en, illegal} === 3'b000 && wr_data === '0 && wr_idx === '0,
        "R10 reset outputs", {stall, wr_en, illegal, wr_idx, wr_data[20:0]}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: stores read zero after reset
    run_op(0, base_for(3, 0), 0, 1'b0, 0, 7'd9, 1'b0, "R10 port0");
    run_op(1, base_for(30, 8), 8, 1'b0, 0, 7'd10, 1'b0, "R10 port1");
    // R5: fill each copy separately with distinct patterns
    for (int p = 0; p < 2; p++) for (int s = 0; s < 32; s++)
      load(2'(1 << p), s, 10'((s * 37 + p * 101 + 3) & 10'h3FF), 8'((s * 13) ^ (p * 8'hA5)));
    load(2'b11, 5, 10'h2AA, 8'h5A); // R5 both copies at once
    // R1 R3 R4 sweep: every set on every port, varied offsets and guards
    for (int p = 0; p < 2; p++) for (int s = 0; s < 32; s++) for (int k = 0; k < 2; k++) begin
      int off;
      off = offs[(s + k) % 6];
      run_op(p, base_for(s, off), off, k[0], nxt() | 32'd1, 7'((s * 3 + p + k * 64) & 127),
             1'b0, "sweep");
    end
    // R6: false guard with upper bits set
    run_op(0, base_for(7, 4), 4, 1'b1, 32'hFFFF_FFFE, 7'd20, 1'b0, "R6 guard false");
    run_op(1, base_for(7, 4), 4, 1'b1, 32'h0000_0001, 7'd21, 1'b0, "R6 guard true");
    // R7: absent guard ignores guard value
    run_op(1, base_for(12, -8), -8, 1'b0, 32'h0, 7'd22, 1'b0, "R7 no guard");
    // R2: offset boundaries and misalignment
    run_op(0, base_for(1, 0), 256, 1'b0, 0, 7'd30, 1'b0, "R2 above max");
    run_op(0, base_for(1, 0), -260, 1'b0, 0, 7'd31, 1'b0, "R2 below min");
    run_op(1, base_for(1, 0), 2, 1'b0, 0, 7'd32, 1'b0, "R2 misaligned");
    run_op(1, base_for(1, 0), 511, 1'b1, 32'd0, 7'd33, 1'b0, "R2 illegal guard false");
    run_op(0, base_for(1, 0), -512, 1'b0, 0, 7'd34, 1'b0, "R2 most negative");
    // R9: issue held during stall is dropped
    run_op(0, base_for(5, 0), 0, 1'b0, 0, 7'd40, 1'b1, "R9 repeat");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule